// File: doc/BRIEF.md
# Multi-Channel Tick Timer Table Engine

This block keeps a set of software timers in a small internal table and serves them all with one sequential scanner. Each table entry holds a 16-bit reload period and a 16-bit current count. A separate enable flag and a separate mode flag are kept for each timer. When a periodic tick arrives and the tick source is enabled, the scanner walks the entries from the lowest index to the highest, one clock per entry. For each enabled timer it decrements the count. When a timer expires it raises that timer's bit on a one-cycle event vector. A restarting timer then reloads its period. A one-shot timer disables itself.

The host changes a timer only through a single 32-bit command word, written with a one-cycle strobe. The command either arms a timer, giving its period and its mode, or disarms it. Every command is first held in a register and applied on its own cycle, between two entry visits, so it never competes with a scanner write. A free-running 32-bit tick counter advances only when a scan reaches the last entry. If a new tick restarts the scan before the last entry is reached, the unfinished tick is not counted.

Top module: `tick_timer_table`

## Requirements
- R1: After reset, `expire` is all zero, `tick_count` is zero and every timer is disabled, so a tick produces no expiry.
- R2: Command word fields: bit 31 is the enable flag, bit 30 is the mode flag (1 = restart, 0 = one-shot), bits 19:16 give the timer index and bits 15:0 give the period. Bits 29:20 are ignored. A command is applied one cycle after its strobe and stalls the scanner for that cycle.
- R3: A command with bit 31 set loads the period into both the reload field and the count field of the selected entry, sets its mode and enables it. A period of 0 behaves like a period of 1.
- R4: A command with bit 31 clear disables the selected timer, which then produces no further expiries.
- R5: A tick with `tick_en` high starts a scan that visits entries 0 to NUM_TIMERS-1 in order, one entry per clock. Timer k's expiry pulse is high for exactly one cycle, beginning k+1 clocks after the clock edge that samples the tick. At most one `expire` bit is high in any cycle.
- R6: An enabled timer in restart mode with period P expires once every P ticks.
- R7: An enabled timer in one-shot mode with period P expires once, on the P-th tick, and then stays disabled.
- R8: `tick_count` increases by exactly one when the scan visits the last entry, and at no other time.
- R9: A tick that arrives before the scan reaches the last entry restarts the scan at entry 0. The unfinished tick is not counted.
- R10: While `tick_en` is low, ticks start no scan. Counts, expiries and `tick_count` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle tick pulse |
| tick_en | input | 1 | Tick source enable |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word |
| expire | output | NUM_TIMERS | One-cycle expiry event, one bit per timer |
| tick_count | output | COUNT_W | Count of completed scans |

## Verification
The situations hardest to reach from the ports are a tick that lands while a scan is still running and a command that lands in the middle of a scan. The bench reaches the first by sending a second tick five cycles after the first. It then shows that `tick_count` rose by one rather than two. It reaches the second by writing an arm command three cycles after a tick. It then shows that the stalled scan still completes and that the new timer fires on the following tick. Expiry timing is checked to the exact cycle by counting clocks from the edge that samples a tick.

// File: rtl/tick_timer_table.sv
module tick_timer_table #(
  parameter int NUM_TIMERS = 16,
  parameter int COUNT_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  tick_en,
  input  logic                  cmd_wr,
  input  logic [31:0]           cmd_word,
  output logic [NUM_TIMERS-1:0] expire,
  output logic [COUNT_W-1:0]    tick_count
);
  localparam int IDX_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_TIMERS - 1);

  logic [15:0]           period_q [NUM_TIMERS];
  logic [15:0]           count_q  [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] valid_q, mode_q;
  logic [IDX_W-1:0]      ptr_q;
  logic                  busy_q, pend_q;
  logic [31:0]           pcmd_q;

  wire start = tick & tick_en;
  wire visit = busy_q & ~start & ~pend_q;
  wire [IDX_W-1:0] ctn = pcmd_q[16 +: IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TIMERS; i++) begin
        period_q[i] <= '0;
        count_q[i]  <= '0;
      end
      valid_q    <= '0;
      mode_q     <= '0;
      ptr_q      <= '0;
      busy_q     <= 1'b0;
      pend_q     <= 1'b0;
      pcmd_q     <= '0;
      expire     <= '0;
      tick_count <= '0;
    end else begin
      expire <= '0;
      if (cmd_wr) begin
        pend_q <= 1'b1;
        pcmd_q <= cmd_word;
      end else if (pend_q) begin
        pend_q <= 1'b0;
      end
      if (pend_q) begin
        if (pcmd_q[31]) begin
          period_q[ctn] <= pcmd_q[15:0];
          count_q[ctn]  <= pcmd_q[15:0];
          mode_q[ctn]   <= pcmd_q[30];
          valid_q[ctn]  <= 1'b1;
        end else begin
          valid_q[ctn]  <= 1'b0;
        end
      end
      if (start) begin
        busy_q <= 1'b1;
        ptr_q  <= '0;
      end else if (visit) begin
        if (valid_q[ptr_q]) begin
          if (count_q[ptr_q] <= 16'd1) begin
            expire[ptr_q] <= 1'b1;
            if (mode_q[ptr_q]) begin
              count_q[ptr_q] <= period_q[ptr_q];
            end else begin
              count_q[ptr_q] <= '0;
              valid_q[ptr_q] <= 1'b0;
            end
          end else begin
            count_q[ptr_q] <= count_q[ptr_q] - 16'd1;
          end
        end
        if (ptr_q == LAST) begin
          busy_q     <= 1'b0;
          tick_count <= tick_count + 1'b1;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tick_timer_table_chk.sv
module tick_timer_table_chk #(
  parameter int NUM_TIMERS = 16,
  parameter int COUNT_W    = 32,
  parameter int IDX_W      = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_TIMERS-1:0] expire,
  input logic [COUNT_W-1:0]    tick_count,
  input logic [NUM_TIMERS-1:0] valid_q,
  input logic [IDX_W-1:0]      ptr_q,
  input logic                  busy_q
);
  assert_single_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(expire));

  assert_pulse_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire != '0) |=> ((expire & $past(expire)) == '0));

  assert_expiry_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((expire & ~$past(valid_q)) == '0));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_count != $past(tick_count)) |-> (tick_count == $past(tick_count) + 1'b1));

  assert_count_at_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_count != $past(tick_count)) |-> ($past(busy_q) && $past(ptr_q) == IDX_W'(NUM_TIMERS - 1)));
endmodule

bind tick_timer_table tick_timer_table_chk #(
  .NUM_TIMERS(NUM_TIMERS), .COUNT_W(COUNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .expire(expire), .tick_count(tick_count),
  .valid_q(valid_q), .ptr_q(ptr_q), .busy_q(busy_q)
);

// File: tb/test_tick_timer_table.sv
module test_tick_timer_table;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int GAP = N + 4;

  logic clk = 0, rst_n = 0, tick = 0, tick_en = 1, cmd_wr = 0;
  logic [31:0] cmd_word = '0;
  logic [N-1:0] expire;
  logic [31:0] tick_count;

  tick_timer_table i_tick_timer_table (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tick_en(tick_en),
    .cmd_wr(cmd_wr), .cmd_word(cmd_word), .expire(expire), .tick_count(tick_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int cnt [N];
  initial for (int i = 0; i < N; i++) cnt[i] = 0;
  always @(negedge clk)
    if (rst_n) for (int i = 0; i < N; i++) if (expire[i]) cnt[i]++;

  typedef struct packed {
    logic [3:0]  tn;
    logic        rst;
    logic [15:0] per;
    logic [7:0]  nt;
    logic [7:0]  nexp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{tn:4'd3,  rst:1'b1, per:16'd2, nt:8'd7, nexp:8'd3},
    '{tn:4'd0,  rst:1'b0, per:16'd3, nt:8'd8, nexp:8'd1},
    '{tn:4'd15, rst:1'b1, per:16'd1, nt:8'd5, nexp:8'd5},
    '{tn:4'd9,  rst:1'b0, per:16'd5, nt:8'd4, nexp:8'd0},
    '{tn:4'd7,  rst:1'b1, per:16'd4, nt:8'd9, nexp:8'd2},
    '{tn:4'd12, rst:1'b1, per:16'd0, nt:8'd3, nexp:8'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic v, input logic r, input logic [3:0] tn,
                      input logic [15:0] per, input logic [9:0] junk);
    @(negedge clk);
    cmd_wr = 1;
    cmd_word = {v, r, junk, tn, per};
    @(negedge clk);
    cmd_wr = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic do_tick();
    pulse_tick();
    repeat (GAP) @(negedge clk);
  endtask

  logic done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0, t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 expire at reset", expire, 0);
    chk("R1 tick_count at reset", tick_count, 0);
    do_tick();
    c0 = 0;
    for (int i = 0; i < N; i++) c0 += cnt[i];
    chk("R1 no expiry when all disabled", c0, 0);
    chk("R8 count after one scan", tick_count, 1);

    foreach (VECS[k]) begin
      send(1'b1, VECS[k].rst, VECS[k].tn, VECS[k].per, 10'd0);
      c0 = cnt[VECS[k].tn];
      t0 = tick_count;
      for (int j = 0; j < VECS[k].nt; j++) do_tick();
      chk(VECS[k].rst ? "R6 restart expiries" : "R7 one-shot expiries",
          cnt[VECS[k].tn] - c0, VECS[k].nexp);
      chk("R3 R8 ticks counted", tick_count - t0, VECS[k].nt);
    end

    // R4: disable timer 3 (restart, period 2)
    send(1'b0, 1'b1, 4'd3, 16'd2, 10'd0);
    c0 = cnt[3];
    repeat (4) do_tick();
    chk("R4 disabled timer silent", cnt[3] - c0, 0);

    // R2: reserved bits set, timer 10 restart period 2
    send(1'b1, 1'b1, 4'd10, 16'd2, 10'h3FF);
    c0 = cnt[10];
    repeat (4) do_tick();
    chk("R2 reserved bits ignored", cnt[10] - c0, 2);

    // R5: exact pulse timing for timer 6, period 1
    send(1'b1, 1'b1, 4'd6, 16'd1, 10'd0);
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
    repeat (6) @(negedge clk);
    chk("R5 timer 6 one cycle early", expire[6], 0);
    @(negedge clk);
    chk("R5 timer 6 pulse on time", expire[6], 1);
    @(negedge clk);
    chk("R5 timer 6 pulse one cycle", expire[6], 0);
    repeat (GAP) @(negedge clk);

    // R9: overrun
    t0 = tick_count;
    pulse_tick();
    repeat (5) @(negedge clk);
    pulse_tick();
    repeat (GAP) @(negedge clk);
    chk("R9 overrun tick not counted", tick_count - t0, 1);

    // R10: tick source disabled
    tick_en = 0;
    t0 = tick_count;
    c0 = cnt[15];
    repeat (3) do_tick();
    chk("R10 no count when disabled", tick_count - t0, 0);
    chk("R10 no expiry when disabled", cnt[15] - c0, 0);
    tick_en = 1;

    // R2: command in mid scan stalls but scan completes
    t0 = tick_count;
    pulse_tick();
    repeat (3) @(negedge clk);
    cmd_wr = 1;
    cmd_word = {1'b1, 1'b1, 10'd0, 4'd11, 16'd1};
    @(negedge clk);
    cmd_wr = 0;
    repeat (GAP) @(negedge clk);
    chk("R2 scan completes after mid-scan command", tick_count - t0, 1);
    c0 = cnt[11];
    do_tick();
    chk("R2 mid-scan command applied", cnt[11] - c0, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule